// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 65,536 words of 24 bits. The host issues one word per request over a valid/ready handshake. Each request carries a write flag, a 16-bit word address, a source-select flag and write data. The controller turns each request into a pin-level memory cycle that is timed by counting clock cycles. For reads it returns the word with a single-cycle response strobe.

The memory is selected only when its active-low chip enable is low and its active-high chip enable is high. The output enable and write enable are both active low. The memory address is split into 15 low bits and a top bit. The memory takes the top bit from one of two lines: a direct address line, or an alternate select line. A source-select pin chooses which one: high picks the alternate line, low picks the direct line. The minimum widths are given as times in picoseconds and the clock period is a parameter. Each phase length is the required time rounded up to whole clock cycles. The data bus is a split output/enable/input triple, which stands for a tristate pad.

A write runs in three steps. First one setup cycle with write enable high. Then the write-enable pulse. Then one hold cycle with write enable high again. A read runs in two steps. First one turnaround cycle with the bus released and output enable high. Then the output-enable window, at whose last edge the data is sampled.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and after reset both chip enables are inactive (`mem_ce_n`=1, `mem_ce`=0). Output and write enables are high, the data bus is not driven (`mem_dq_oe`=0), `req_ready`=1 and `rsp_valid`=0.
- R2: A write request stores its 24-bit data at word index {addr[15], addr[14:0]}. The controller drives the data bus during the whole write-enable pulse.
- R3: A read request returns the word at {addr[15], addr[14:0]} on `rsp_rdata`. `rsp_valid` is high for exactly one cycle per read.
- R4: With the source-select flag at 1, the controller drives `mem_src`=1, places addr[15] on `mem_alt` and holds `mem_msb` at 0. With the flag at 0, it drives `mem_src`=0, places addr[15] on `mem_msb` and holds `mem_alt` at 0. In both cases the same word is reached.
- R5: The write-enable pulse lasts exactly ceil(max(pulse, address-to-end, select-to-end, data setup) / clock period) cycles. That is 2 cycles at the defaults (7 ns minimums, 4 ns clock).
- R6: The output-enable window lasts exactly ceil(read cycle time / clock period) cycles, which is 3 cycles at the defaults (10 ns, 4 ns clock).
- R7: The data bus is released for at least one full cycle before output enable goes low. It stays released while output enable is low.
- R8: Write enable or output enable is low only while the memory is selected (`mem_ce_n`=0 and `mem_ce`=1).
- R9: While the memory stays selected, the address, top-bit lines and source-select pin do not change. The write data does not change while it is driven, which covers one hold cycle after write enable rises.
- R10: `req_ready` is low from the cycle after a request is accepted until the memory is deselected again. Each write takes 2+R5 cycles and each read 1+R6 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address; bit 15 is the top bit |
| req_alt_sel | input | 1 | 1 = route top bit through the alternate select line |
| req_wdata | input | 24 | Write data |
| rsp_valid | output | 1 | One-cycle strobe for returned read data |
| rsp_rdata | output | 24 | Read data |
| mem_addr | output | 15 | Low memory address bits |
| mem_msb | output | 1 | Direct top address line |
| mem_alt | output | 1 | Alternate top-bit select line |
| mem_src | output | 1 | Top-bit source select (1 = alternate) |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 24 | Data bus output value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 24 | Data bus input value |

## Verification
The hardest case to reach is a word reached through both top-bit routes. A word is written with the top bit on the alternate line, then read back with the top bit on the direct line. A second word whose index differs only in the top bit is then written and read back. This shows that the two routes alias one word and that the top bit is never lost. The bench memory model indexes its store only from the pins (source-select, the chosen line, low address). A routing error therefore shows up as a wrong read word. A write followed at once by a read of the same word exercises the bus turnaround. Throughout the run, a pin monitor measures every enable pulse length and flags any cycle in which the controller and the memory could both drive the bus.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int ADDR_W = 16;
    localparam int LO_W   = ADDR_W - 1;
    localparam int DATA_W = 24;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WSET = 3'd1,
        ST_WPUL = 3'd2,
        ST_WHLD = 3'd3,
        ST_RTRN = 3'd4,
        ST_RACC = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic              wr;
        logic              alt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } host_req_t;

    function automatic int cyc_ceil(input int ps, input int clk_ps);
        return (ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_sequencer.sv
module asram_sequencer
    import asram_pkg::*;
#(
    parameter int CW     = 2,
    parameter int WE_CYC = 2,
    parameter int RD_CYC = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  host_req_t     req_in,
    input  logic          tmr_done,
    output seq_state_e    state_d,
    output host_req_t     cur_req,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          req_ready,
    output logic          capture
);
    seq_state_e state_q;
    host_req_t  req_q;
    logic       accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign cur_req   = accept ? req_in : req_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (req_valid) state_d = req_in.wr ? ST_WSET : ST_RTRN;
            ST_WSET: state_d = ST_WPUL;
            ST_WPUL: if (tmr_done) state_d = ST_WHLD;
            ST_WHLD: state_d = ST_IDLE;
            ST_RTRN: state_d = ST_RACC;
            ST_RACC: if (tmr_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign tmr_load = (state_q == ST_WSET) || (state_q == ST_RTRN);
    assign tmr_val  = (state_q == ST_WSET) ? CW'(WE_CYC - 1) : CW'(RD_CYC - 1);
    assign capture  = (state_q == ST_RACC) && tmr_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) req_q <= req_in;
        end
    end

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

endmodule

// File: rtl/asram_pin_stage.sv
module asram_pin_stage
    import asram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state_d,
    input  host_req_t         cur_req,
    output logic [LO_W-1:0]   mem_addr,
    output logic              mem_msb,
    output logic              mem_alt,
    output logic              mem_src,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);
    logic sel, wr_pulse, rd_win, drive, top;

    assign sel      = (state_d != ST_IDLE);
    assign wr_pulse = (state_d == ST_WPUL);
    assign rd_win   = (state_d == ST_RACC);
    assign drive    = (state_d == ST_WSET) || (state_d == ST_WPUL) || (state_d == ST_WHLD);
    assign top      = cur_req.addr[ADDR_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr   <= '0;
            mem_msb    <= 1'b0;
            mem_alt    <= 1'b0;
            mem_src    <= 1'b0;
            mem_ce_n   <= 1'b1;
            mem_ce     <= 1'b0;
            mem_oe_n   <= 1'b1;
            mem_we_n   <= 1'b1;
            mem_dq_out <= '0;
            mem_dq_oe  <= 1'b0;
        end else begin
            mem_addr   <= sel ? cur_req.addr[LO_W-1:0] : '0;
            mem_src    <= sel && cur_req.alt;
            mem_msb    <= sel && !cur_req.alt && top;
            mem_alt    <= sel && cur_req.alt && top;
            mem_ce_n   <= !sel;
            mem_ce     <= sel;
            mem_oe_n   <= !rd_win;
            mem_we_n   <= !wr_pulse;
            mem_dq_out <= drive ? cur_req.data : '0;
            mem_dq_oe  <= drive;
        end
    end

    // R7
    bus_released_before_oe_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_dq_oe && !$past(mem_dq_oe)));

    // R8
    enables_need_select_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n || !mem_oe_n) |-> (!mem_ce_n && mem_ce));

    // R2
    data_driven_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_dq_oe);

    // R9
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |->
            ($stable(mem_addr) && $stable(mem_src) && $stable(mem_msb) && $stable(mem_alt)));

    // R9
    data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    // R4
    unused_top_line_low_chk: assert property (@(posedge clk) disable iff (rst)
        mem_src ? !mem_msb : !mem_alt);

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import asram_pkg::*;
#(
    parameter int CLK_PS  = 4000,
    parameter int T_WP_PS = 7000,
    parameter int T_AW_PS = 7000,
    parameter int T_VW_PS = 7000,
    parameter int T_DS_PS = 5000,
    parameter int T_RC_PS = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_alt_sel,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [LO_W-1:0]   mem_addr,
    output logic              mem_msb,
    output logic              mem_alt,
    output logic              mem_src,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int WE_RAW = cyc_ceil(imax(imax(T_WP_PS, T_AW_PS), imax(T_VW_PS, T_DS_PS)), CLK_PS);
    localparam int WE_CYC = imax(WE_RAW, 1);
    localparam int RD_CYC = imax(cyc_ceil(T_RC_PS, CLK_PS), 1);
    localparam int CW     = imax($clog2(imax(WE_CYC, RD_CYC) + 1), 1);

    host_req_t     req_in, cur_req;
    seq_state_e    state_d;
    logic          tmr_load, tmr_done, capture;
    logic [CW-1:0] tmr_val;

    assign req_in = '{wr: req_write, alt: req_alt_sel, addr: req_addr, data: req_wdata};

    asram_sequencer #(.CW(CW), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .tmr_done  (tmr_done),
        .state_d   (state_d),
        .cur_req   (cur_req),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .req_ready (req_ready),
        .capture   (capture)
    );

    asram_phase_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    asram_pin_stage u_pins (
        .clk        (clk),
        .rst        (rst),
        .state_d    (state_d),
        .cur_req    (cur_req),
        .mem_addr   (mem_addr),
        .mem_msb    (mem_msb),
        .mem_alt    (mem_alt),
        .mem_src    (mem_src),
        .mem_ce_n   (mem_ce_n),
        .mem_ce     (mem_ce),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= mem_dq_in;
        end
    end

    // R3
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R3
    rsp_after_read_window_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!$past(mem_oe_n) && mem_oe_n));

    // R10
    idle_means_deselected_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && !mem_ce));

endmodule

// File: tb/test_sram_seq_ctrl.sv
module test_sram_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_alt_sel = 1'b0;
    logic [15:0] req_addr = '0;
    logic [23:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [23:0] rsp_rdata;
    logic [14:0] mem_addr;
    logic        mem_msb, mem_alt, mem_src, mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [23:0] mem_dq_out;
    logic [23:0] mem_dq_in = 24'hBADBAD;

    localparam int EXP_WE = (7000 + 3999) / 4000;
    localparam int EXP_OE = (10000 + 3999) / 4000;

    int errors = 0, checks = 0;
    logic [23:0] dev_mem [int unsigned];
    logic [23:0] exp_mem [int unsigned];
    logic [23:0] exp_q [$];
    logic        cur_alt = 1'b0, cur_top = 1'b0;
    int          we_run = 0, oe_run = 0, clash = 0;
    logic        rsp_prev = 1'b0;

    always #2 clk = ~clk;

    sram_seq_ctrl i_sram_seq_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_alt_sel(req_alt_sel),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_msb(mem_msb), .mem_alt(mem_alt), .mem_src(mem_src),
        .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int unsigned pin_index();
        return {16'd0, (mem_src ? mem_alt : mem_msb), mem_addr};
    endfunction

    // memory model: stores on rising write enable, presents data while reading
    always @(posedge mem_we_n)
        if (!mem_ce_n && mem_ce && mem_dq_oe) dev_mem[pin_index()] = mem_dq_out;

    always @(negedge clk) begin
        if (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n)
            mem_dq_in <= dev_mem.exists(pin_index()) ? dev_mem[pin_index()] : 24'h0;
        else
            mem_dq_in <= 24'hBADBAD;
    end

    // monitor: pulse widths, routing, contention, responses
    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_we_n) we_run++;
            else if (we_run != 0) begin
                check(we_run == EXP_WE, "R5 write pulse width", we_run, EXP_WE);
                we_run = 0;
            end
            if (!mem_oe_n) oe_run++;
            else if (oe_run != 0) begin
                check(oe_run == EXP_OE, "R6 read window width", oe_run, EXP_OE);
                oe_run = 0;
            end
            if (!mem_oe_n && mem_dq_oe) clash++;
            if ((!mem_we_n || !mem_oe_n) && !(!mem_ce_n && mem_ce))
                check(1'b0, "R8 enable without select", {mem_ce_n, mem_ce}, 2'b01);
            if (!mem_we_n || !mem_oe_n) begin
                check(mem_src == cur_alt, "R4 source pin", mem_src, cur_alt);
                check((cur_alt ? mem_alt : mem_msb) == cur_top, "R4 chosen top line",
                      cur_alt ? mem_alt : mem_msb, cur_top);
                check((cur_alt ? mem_msb : mem_alt) == 1'b0, "R4 unused top line",
                      cur_alt ? mem_msb : mem_alt, 0);
            end
            if (rsp_valid) begin
                check(!rsp_prev, "R3 single-cycle strobe", rsp_prev, 0);
                if (exp_q.size() == 0) check(1'b0, "R3 unexpected response", rsp_rdata, 0);
                else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    check(rsp_rdata == e, "R3 R2 read data", rsp_rdata, e);
                end
            end
            rsp_prev = rsp_valid;
        end
    end

    task automatic issue(input bit wr, input logic [15:0] a, input bit alt, input logic [23:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_alt_sel = alt; req_wdata = d;
        cur_alt = alt; cur_top = a[15];
        if (wr) exp_mem[{16'd0, a}] = d;
        else exp_q.push_back(exp_mem.exists({16'd0, a}) ? exp_mem[{16'd0, a}] : 24'h0);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R10 busy after accept", req_ready, 0);
    endtask

    task automatic measure_busy(input bit wr, input int exp_cyc);
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = 16'h0042; req_alt_sel = 1'b0;
        req_wdata = 24'h13579B; cur_alt = 1'b0; cur_top = 1'b0;
        if (wr) exp_mem[32'h42] = 24'h13579B;
        else exp_q.push_back(exp_mem[32'h42]);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!req_ready) begin n++; @(negedge clk); end
        check(n == exp_cyc, "R10 busy length", n, exp_cyc);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(mem_ce_n && !mem_ce, "R1 chip enables idle", {mem_ce_n, mem_ce}, 2'b10);
        check(mem_oe_n && mem_we_n, "R1 oe/we high", {mem_oe_n, mem_we_n}, 2'b11);
        check(!mem_dq_oe, "R1 bus released", mem_dq_oe, 0);
        check(req_ready && !rsp_valid, "R1 ready, no response", {req_ready, rsp_valid}, 2'b10);

        // R2 R3 basic write/read, direct route
        issue(1, 16'h0001, 0, 24'hA5A5A5);
        issue(1, 16'h7FFF, 0, 24'hFFFFFF);
        issue(0, 16'h0001, 0, 0);
        issue(0, 16'h7FFF, 0, 0);
        issue(0, 16'h1234, 0, 0);

        // R4 alternate route aliases the direct route for the same top bit
        issue(1, 16'h8005, 1, 24'h00C0DE);
        issue(0, 16'h8005, 0, 0);
        issue(1, 16'h0005, 1, 24'h123456);
        issue(0, 16'h8005, 1, 0);
        issue(0, 16'h0005, 0, 0);
        issue(1, 16'hFFFF, 0, 24'h800001);
        issue(0, 16'hFFFF, 1, 0);

        // R7 write immediately followed by read of the same word
        issue(1, 16'h4321, 1, 24'h0F0F0F);
        issue(0, 16'h4321, 1, 0);

        // mixed pattern
        for (int i = 0; i < 24; i++) begin
            logic [15:0] a;
            a = 16'(i * 16'h2A5B + 16'h0107);
            issue(1, a, i[0], 24'(i * 24'h03F1C7 + 24'h000101));
            if (i % 3 == 2) issue(0, a, ~i[0], 0);
        end
        for (int i = 0; i < 24; i++)
            issue(0, 16'(i * 16'h2A5B + 16'h0107), i[1], 0);

        // R10 cycle occupancy
        measure_busy(1, EXP_WE + 2);
        measure_busy(0, EXP_OE + 1);

        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);
        check(clash == 0, "R7 no drive during output enable", clash, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule